// File: doc/BRIEF.md
# Debug trace capture controller

This block runs one debug capture session at a time and owns the small trace buffer behind it. Software-facing logic (outside this block) turns register writes into single-cycle arm and disarm pulses and a module enable level. A separate comparator stage supplies a qualified trigger pulse and two comparator hit pulses. Each cycle may carry a capture strobe together with a 16-bit change-of-flow address and an 8-bit event byte. The block decides which strobes to keep, keeps them in an eight-entry buffer, and ends the session by itself.

Two kinds of session are supported. A begin-type session waits for the trigger, keeps the strobe that arrives with the trigger and every strobe after it, and ends when the buffer is full. An end-type session keeps strobes from the moment it is armed, overwrites the oldest entry once the buffer is full, and ends on the trigger. Event-only mode stores the event byte zero-extended instead of the address and always runs as a begin-type session. Once no session is armed, a read port pops entries from oldest to newest.

The state machine has four states. `ST_IDLE` means not armed. `ST_WAIT_TRIG` is a begin-type session waiting for the trigger. `ST_CAPTURE` is a begin-type session that is storing. `ST_CIRCULAR` is an end-type session. The transitions are:
- arm: any state goes to `ST_WAIT_TRIG`, or to `ST_CIRCULAR` when end-type is selected outside event-only mode.
- stop: any state goes to `ST_IDLE` when enable is low or a disarm pulse arrives. Stop has priority over arm.
- trigger: `ST_WAIT_TRIG` goes to `ST_CAPTURE`.
- fill: `ST_CAPTURE` goes to `ST_IDLE` when the eighth entry is written.
- end: `ST_CIRCULAR` goes to `ST_IDLE` on the trigger.

Top module: `dbg_trace_ctrl`

## Requirements
- R1: After reset, armed_o, hit_a_o and hit_b_o are 0, count_o is 0 and rd_data_o is 0.
- R2: An arm pulse with enable high and no disarm pulse makes armed_o 1 on the next cycle, with count_o 0 and both hit flags 0. This also restarts a session that is already armed.
- R3: A disarm pulse, or enable low, makes armed_o 0 on the next cycle and takes priority over an arm pulse. Stored entries are kept.
- R4: In a begin-type session, strobes before the trigger are not stored. The strobe in the trigger cycle and every later strobe are stored. armed_o falls in the cycle after the eighth entry is written.
- R5: In an end-type session, every strobe from arming onward is stored. A strobe into a full buffer drops the oldest entry, and count_o stays at 8. armed_o falls after the trigger cycle, and a strobe in that cycle is still stored.
- R6: When event-only is set at arming, each entry is {8'h00, cap_data_i}, and the session runs as begin-type whatever end_mode_i says.
- R7: Outside event-only mode, each entry is the full 16-bit cap_addr_i.
- R8: A hit pulse on hit_a_i or hit_b_i in an armed cycle sets the matching flag. The flag holds until the next arm.
- R9: rd_data_o shows the oldest entry, or 0 when the buffer is empty. rd_i while not armed and count_o > 0 drops the oldest entry and decrements count_o. rd_i while armed has no effect.
- R10: After a session ends, strobes and triggers change nothing until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Module enable level |
| arm_set_i | input | 1 | Arm pulse (start a session) |
| arm_clr_i | input | 1 | Disarm pulse (stop a session) |
| end_mode_i | input | 1 | 1 selects an end-type session, 0 a begin-type session |
| event_only_i | input | 1 | Event-only mode, sampled at arming |
| trig_i | input | 1 | Qualified trigger pulse |
| hit_a_i | input | 1 | Comparator A hit pulse |
| hit_b_i | input | 1 | Comparator B hit pulse |
| cap_vld_i | input | 1 | Capture strobe |
| cap_addr_i | input | 16 | Change-of-flow address |
| cap_data_i | input | 8 | Event data byte |
| rd_i | input | 1 | Read pop request |
| armed_o | output | 1 | A session is armed |
| hit_a_o | output | 1 | Comparator A hit flag |
| hit_b_o | output | 1 | Comparator B hit flag |
| count_o | output | 4 | Number of stored entries |
| rd_data_o | output | 16 | Oldest stored entry |

## Verification
The hardest case to reach is the end-type overwrite. The buffer must already be full when another strobe arrives, and a trigger must come with a strobe in the same cycle, so that the kept window is the last eight addresses. The stimulus arms an end-type session and sends eleven consecutive strobes, raising the trigger only on the eleventh. Draining the buffer then shows whether exactly the three oldest entries were dropped.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_TRIG,
        ST_CAPTURE,
        ST_CIRCULAR
    } trc_state_e;
endpackage

// File: rtl/dbg_trace_fifo.sv
module dbg_trace_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         wr_i,
    input  logic [WIDTH-1:0]             wdata_i,
    input  logic                         rd_i,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         last_o,
    output logic [WIDTH-1:0]             rdata_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             full, pop;

    assign full = (cnt == FULL_CNT);
    assign pop  = rd_i && (cnt != '0) && !wr_i;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_i && !clr_i && (wp == PW'(i)))
                mem[i] <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr_i) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (wr_i) begin
            wp <= wp + 1'b1;
            if (full)
                rp <= rp + 1'b1;
            else
                cnt <= cnt + 1'b1;
        end else if (pop) begin
            rp  <= rp + 1'b1;
            cnt <= cnt - 1'b1;
        end
    end

    assign count_o = cnt;
    assign last_o  = (cnt == LAST_CNT);
    assign rdata_o = (cnt == '0) ? '0 : mem[rp];
endmodule

// File: rtl/dbg_trace_fsm.sv
module dbg_trace_fsm
    import dbg_trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       arm_set_i,
    input  logic       arm_clr_i,
    input  logic       end_mode_i,
    input  logic       event_only_i,
    input  logic       trig_i,
    input  logic       cap_vld_i,
    input  logic       rd_req_i,
    input  logic       fifo_last_i,
    output logic       armed_o,
    output logic       start_o,
    output logic       wr_o,
    output logic       rd_o
);
    trc_state_e state, nxt;
    logic       stop;

    assign stop    = !enable_i || arm_clr_i;
    assign start_o = !stop && arm_set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (stop) begin
            nxt = ST_IDLE;
        end else if (start_o) begin
            nxt = (event_only_i || !end_mode_i) ? ST_WAIT_TRIG : ST_CIRCULAR;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_WAIT_TRIG: if (trig_i) nxt = ST_CAPTURE;
                ST_CAPTURE:   if (cap_vld_i && fifo_last_i) nxt = ST_IDLE;
                ST_CIRCULAR:  if (trig_i) nxt = ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_o    = 1'b0;
        rd_o    = 1'b0;
        armed_o = 1'b1;
        unique case (state)
            ST_IDLE: begin
                armed_o = 1'b0;
                rd_o    = rd_req_i && !start_o;
            end
            ST_WAIT_TRIG: wr_o = cap_vld_i && trig_i && !stop && !start_o;
            ST_CAPTURE:   wr_o = cap_vld_i && !stop && !start_o;
            ST_CIRCULAR:  wr_o = cap_vld_i && !stop && !start_o;
            default:      armed_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbg_trace_ctrl.sv
module dbg_trace_ctrl #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int EVT_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable_i,
    input  logic                        arm_set_i,
    input  logic                        arm_clr_i,
    input  logic                        end_mode_i,
    input  logic                        event_only_i,
    input  logic                        trig_i,
    input  logic                        hit_a_i,
    input  logic                        hit_b_i,
    input  logic                        cap_vld_i,
    input  logic [ADDR_W-1:0]           cap_addr_i,
    input  logic [EVT_W-1:0]            cap_data_i,
    input  logic                        rd_i,
    output logic                        armed_o,
    output logic                        hit_a_o,
    output logic                        hit_b_o,
    output logic [$clog2(DEPTH+1)-1:0]  count_o,
    output logic [ADDR_W-1:0]           rd_data_o
);
    localparam int PAD_W = ADDR_W - EVT_W;

    logic              start, wr, rd, last, ev_q;
    logic [ADDR_W-1:0] wdata;

    dbg_trace_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .arm_set_i    (arm_set_i),
        .arm_clr_i    (arm_clr_i),
        .end_mode_i   (end_mode_i),
        .event_only_i (event_only_i),
        .trig_i       (trig_i),
        .cap_vld_i    (cap_vld_i),
        .rd_req_i     (rd_i),
        .fifo_last_i  (last),
        .armed_o      (armed_o),
        .start_o      (start),
        .wr_o         (wr),
        .rd_o         (rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q    <= 1'b0;
            hit_a_o <= 1'b0;
            hit_b_o <= 1'b0;
        end else if (start) begin
            ev_q    <= event_only_i;
            hit_a_o <= 1'b0;
            hit_b_o <= 1'b0;
        end else if (armed_o) begin
            if (hit_a_i) hit_a_o <= 1'b1;
            if (hit_b_i) hit_b_o <= 1'b1;
        end
    end

    assign wdata = ev_q ? {{PAD_W{1'b0}}, cap_data_i} : cap_addr_i;

    dbg_trace_fifo #(.DEPTH(DEPTH), .WIDTH(ADDR_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start),
        .wr_i    (wr),
        .wdata_i (wdata),
        .rd_i    (rd),
        .count_o (count_o),
        .last_o  (last),
        .rdata_o (rd_data_o)
    );
endmodule

// File: rtl/dbg_trace_chk.sv
module dbg_trace_chk #(
    parameter int DEPTH = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        enable_i,
    input logic                        arm_set_i,
    input logic                        arm_clr_i,
    input logic                        rd_i,
    input logic                        armed_o,
    input logic                        hit_a_o,
    input logic                        hit_b_o,
    input logic [$clog2(DEPTH+1)-1:0]  count_o
);
    logic start_c, stop_c;
    assign stop_c  = !enable_i || arm_clr_i;
    assign start_c = !stop_c && arm_set_i;

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (armed_o && count_o == '0 && !hit_a_o && !hit_b_o)); // R2

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !armed_o); // R3

    AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_o) <= DEPTH); // R5

    AST_HIT_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a_o && !start_c) |=> hit_a_o); // R8

    AST_HIT_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b_o && !start_c) |=> hit_b_o); // R8

    AST_READ_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && rd_i && count_o != '0 && !start_c) |=> (int'(count_o) == int'($past(count_o)) - 1)); // R9

    AST_ARMED_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !start_c) |=> (count_o >= $past(count_o))); // R9

    AST_IDLE_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !start_c) |=> (count_o <= $past(count_o))); // R10
endmodule

bind dbg_trace_ctrl dbg_trace_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .arm_set_i (arm_set_i),
    .arm_clr_i (arm_clr_i),
    .rd_i      (rd_i),
    .armed_o   (armed_o),
    .hit_a_o   (hit_a_o),
    .hit_b_o   (hit_b_o),
    .count_o   (count_o)
);

// File: tb/sim_dbg_trace_ctrl.sv
module sim_dbg_trace_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable, arm_set, arm_clr, end_mode, ev_only, trig, hit_a, hit_b, cap_vld, rd;
    logic [15:0] cap_addr;
    logic [7:0]  cap_data;
    logic armed, ha_o, hb_o;
    logic [3:0]  count;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_trace_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .arm_set_i(arm_set), .arm_clr_i(arm_clr),
        .end_mode_i(end_mode), .event_only_i(ev_only), .trig_i(trig), .hit_a_i(hit_a),
        .hit_b_i(hit_b), .cap_vld_i(cap_vld), .cap_addr_i(cap_addr), .cap_data_i(cap_data),
        .rd_i(rd), .armed_o(armed), .hit_a_o(ha_o), .hit_b_o(hb_o), .count_o(count),
        .rd_data_o(rdata)
    );

    // behavioural reference model
    logic [15:0] q[$];
    bit m_armed, m_beg, m_trig_seen, m_ev, m_ha, m_hb;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_armed = 0; m_beg = 0; m_trig_seen = 0; m_ev = 0; m_ha = 0; m_hb = 0;
        end else begin
            bit stop, start, old;
            logic [15:0] d;
            stop  = !enable || arm_clr;
            start = !stop && arm_set;
            old   = m_armed;
            d     = m_ev ? {8'h00, cap_data} : cap_addr;
            if (!start && old) begin
                if (hit_a) m_ha = 1;
                if (hit_b) m_hb = 1;
            end
            if (start) begin
                m_armed = 1; m_beg = ev_only || !end_mode; m_ev = ev_only;
                m_trig_seen = 0; q.delete(); m_ha = 0; m_hb = 0;
            end else if (old && !stop) begin
                if (m_beg) begin
                    if (!m_trig_seen) begin
                        if (trig) begin
                            m_trig_seen = 1;
                            if (cap_vld) q.push_back(d);
                        end
                    end else if (cap_vld) begin
                        q.push_back(d);
                        if (q.size() == 8) m_armed = 0;
                    end
                end else begin
                    if (cap_vld) begin
                        if (q.size() == 8) void'(q.pop_front());
                        q.push_back(d);
                    end
                    if (trig) m_armed = 0;
                end
            end else if (!old) begin
                if (rd && q.size() > 0) void'(q.pop_front());
            end
            if (stop) m_armed = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 armed", int'(armed), int'(m_armed));
            chk("R8 hit_a", int'(ha_o), int'(m_ha));
            chk("R8 hit_b", int'(hb_o), int'(m_hb));
            chk("R5 count", int'(count), q.size());
            chk("R9 rd_data", int'(rdata), (q.size() > 0) ? int'(q[0]) : 0);
        end
    end

    task automatic tick();
        @(negedge clk);
        arm_set = 0; arm_clr = 0; cap_vld = 0; trig = 0; rd = 0; hit_a = 0; hit_b = 0;
    endtask

    task automatic strobe(input logic [15:0] a, input logic [7:0] dt, input logic t);
        cap_vld = 1; cap_addr = a; cap_data = dt; trig = t;
        tick();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        enable = 1; arm_set = 0; arm_clr = 0; end_mode = 0; ev_only = 0; trig = 0;
        hit_a = 0; hit_b = 0; cap_vld = 0; cap_addr = 0; cap_data = 0; rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 armed", int'(armed), 0);
        chk("R1 count", int'(count), 0);
        chk("R1 rd_data", int'(rdata), 0);
        chk("R1 hits", int'({ha_o, hb_o}), 0);

        // begin-type, full address mode
        end_mode = 0; ev_only = 0;
        arm_set = 1; tick();
        chk("R2 armed", int'(armed), 1);
        strobe(16'h1100, 8'h00, 0);
        strobe(16'h1101, 8'h00, 0);
        chk("R4 pre-trigger ignored", int'(count), 0);
        strobe(16'h2000, 8'h00, 1);
        for (int k = 1; k < 8; k++) strobe(16'h2000 + 16'(k), 8'h00, 0);
        chk("R4 ended on full", int'(armed), 0);
        chk("R4 count full", int'(count), 8);
        chk("R7 head address", int'(rdata), 16'h2000);
        strobe(16'h2008, 8'h00, 1);
        chk("R10 no store after end", int'(count), 8);
        for (int k = 0; k < 8; k++) begin
            chk("R9 read order", int'(rdata), 16'h2000 + k);
            rd = 1; tick();
        end
        chk("R9 empty count", int'(count), 0);
        chk("R9 empty data", int'(rdata), 0);
        rd = 1; tick();
        chk("R9 read on empty", int'(count), 0);

        // end-type circular with overwrite
        end_mode = 1;
        arm_set = 1; tick();
        for (int k = 0; k < 10; k++) strobe(16'h3000 + 16'(k), 8'h00, 0);
        chk("R5 still armed", int'(armed), 1);
        chk("R5 saturated", int'(count), 8);
        strobe(16'h300A, 8'h00, 1);
        chk("R5 ended on trigger", int'(armed), 0);
        chk("R5 oldest kept", int'(rdata), 16'h3003);
        rd = 1; tick();
        chk("R9 pop next", int'(rdata), 16'h3004);

        // event-only forces begin type, rd while armed ignored, hits
        ev_only = 1; end_mode = 1;
        arm_set = 1; tick();
        chk("R2 rearm clears", int'(count), 0);
        strobe(16'h4455, 8'h11, 0);
        chk("R6 begin-type forced", int'(count), 0);
        strobe(16'h4466, 8'h22, 1);
        chk("R6 event byte", int'(rdata), 16'h0022);
        rd = 1; tick();
        chk("R9 read while armed", int'(count), 1);
        hit_a = 1; tick();
        chk("R8 hit_a set", int'(ha_o), 1);
        chk("R8 hit_b clear", int'(hb_o), 0);
        arm_clr = 1; arm_set = 1; tick();
        chk("R3 disarm wins", int'(armed), 0);
        chk("R3 entries kept", int'(count), 1);
        chk("R8 hit held", int'(ha_o), 1);

        // enable low stops, rearm clears hits
        ev_only = 0; end_mode = 1;
        arm_set = 1; tick();
        chk("R2 hits cleared", int'(ha_o), 0);
        hit_b = 1; strobe(16'h5000, 8'h00, 0);
        chk("R8 hit_b set", int'(hb_o), 1);
        enable = 0; tick();
        chk("R3 enable low stops", int'(armed), 0);
        strobe(16'h5001, 8'h00, 0);
        chk("R10 idle strobe ignored", int'(count), 1);
        enable = 1;
        repeat (3) tick();
        finish_run();
    end
endmodule